// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block turns the two phase signals of an incremental encoder into a signed-direction position count held in a register. A two-bit mode field picks the counting source:

- **Free-running:** count every clock cycle.
- **Phase A only:** count both edges of phase A (two counts per encoder cycle).
- **Phase B only:** count both edges of phase B (two counts per encoder cycle).
- **Both phases:** count both edges of both phases (four counts per encoder cycle).

The count runs between zero and a programmable ceiling, and wraps at either end. A direction flag records whether the most recent count went up or down.

Software uses a small register bus with a combinational read path. The registers are control (enable, ceiling buffering and the direction flag), mode, count, ceiling and a self-clearing update trigger. When ceiling buffering is on, a new ceiling waits in a pending register. It becomes active only on an update event, and the same event also reloads the count. Both encoder phases pass through a synchronizer before edge detection, so the phase pins may be asynchronous to the clock.

Top module: `qenc_counter`

## Requirements
- R1: With mode 0 selected and control bit 0 (enable) set, the count rises by one on every clock edge, and the direction flag reads 0.
- R2: With mode 1 selected, each edge of phase A steps the count. The step is up when A differs from B after the edge and down otherwise. Edges of B leave the count unchanged.
- R3: With mode 2 selected, each edge of phase B steps the count. The step is up when B equals A after the edge and down otherwise. Edges of A leave the count unchanged.
- R4: With mode 3 selected, every edge of either phase steps the count, giving four counts per encoder cycle. A sample in which both phases changed at once causes no count.
- R5: Control readback bit 3 is the direction flag: 0 after an upward step and 1 after a downward step. It keeps its value while no step occurs.
- R6: An upward step from a count at or above the active ceiling gives 0. A downward step from 0 gives the active ceiling.
- R7: With control bit 1 (buffering) clear, a write to the ceiling address (3) becomes active on the next edge. With it set, the written value stays pending, and reads of address 3 keep returning the old active ceiling.
- R8: With enable clear, the count holds its value whatever the phases or mode do. A write to the count address (2) loads the count on the next edge whatever the enable state.
- R9: Writing 1 in bit 0 of the update address (4) makes that bit read 1 for exactly one cycle. On the following edge the pending ceiling becomes active, and the count is loaded with 0 if the direction flag is 0, or with the new ceiling if it is 1.
- R10: A phase change driven onto a pin appears in the count on the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| bus_addr | input | 3 | Register address: 0 control, 1 mode, 2 count, 3 ceiling, 4 update |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |

## Verification
Register writes are visible on the read port after the edge that samples the strobe. The update trigger reads 1 after that edge, and its count and ceiling effects appear one edge later. A phase change needs three edges to reach the count: two for the synchronizer and one for the counter. The bench drives the phases on a falling edge, waits exactly three rising edges, and checks on the following falling edge. The latency test also checks one edge early to confirm that nothing moved before that point. Free-running counts are derived from the number of edges that the enable write task spans, so the expected totals follow from the edge count alone.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

    typedef enum logic [1:0] {
        MODE_INTCLK = 2'd0,
        MODE_X2A    = 2'd1,
        MODE_X2B    = 2'd2,
        MODE_X4     = 2'd3
    } qmode_e;

    typedef struct packed {
        logic step;
        logic down;
    } step_t;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_MODE = 3'd1;
    localparam logic [2:0] ADDR_CNT  = 3'd2;
    localparam logic [2:0] ADDR_CEIL = 3'd3;
    localparam logic [2:0] ADDR_UPD  = 3'd4;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PRE_BIT = 1;
    localparam int CTRL_DIR_BIT = 3;

    // lvl/tog index 0 is phase A, index 1 is phase B
    function automatic step_t decode_step(qmode_e mode, logic [1:0] lvl, logic [1:0] tog);
        step_t s;
        s = '{step: 1'b0, down: 1'b0};
        unique case (mode)
            MODE_INTCLK: s.step = 1'b1;
            MODE_X2A: begin
                s.step = tog[0];
                s.down = (lvl[0] == lvl[1]);
            end
            MODE_X2B: begin
                s.step = tog[1];
                s.down = (lvl[1] != lvl[0]);
            end
            MODE_X4: begin
                if (tog == 2'b01) begin
                    s.step = 1'b1;
                    s.down = (lvl[0] == lvl[1]);
                end else if (tog == 2'b10) begin
                    s.step = 1'b1;
                    s.down = (lvl[1] != lvl[0]);
                end
            end
            default: s = '{step: 1'b0, down: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qenc_edge.sv
`timescale 1ns/1ps
module qenc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic toggle
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign level  = sh_q[STAGES-1];
    assign toggle = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode
    import qenc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  qmode_e          mode,
    input  logic [1:0]      lvl,
    input  logic [1:0]      tog,
    output step_t           stp
);
    assign stp = decode_step(mode, lvl, tog);

    AST_INTCLK_UP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INTCLK) |-> (stp.step && !stp.down)); // R1
    AST_X2A_IGNORES_B: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_X2A && !tog[0]) |-> !stp.step); // R2
    AST_X2B_IGNORES_A: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_X2B && !tog[1]) |-> !stp.step); // R3
    AST_X4_CLASH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_X4 && tog == 2'b11) |-> !stp.step); // R4
endmodule

// File: rtl/qenc_wrap.sv
`timescale 1ns/1ps
module qenc_wrap #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] ceil,
    input  logic             down,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        if (down) nxt = (cur == '0)   ? ceil : cur - ONE;
        else      nxt = (cur >= ceil) ? '0   : cur + ONE;
    end
endmodule

// File: rtl/qenc_counter.sv
`timescale 1ns/1ps
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata
);
    localparam logic [CNT_W-1:0] CEIL_RST = '1;

    logic [1:0] raw, lvl, tog;
    assign raw = {enc_b, enc_a};

    for (genvar i = 0; i < 2; i++) begin : g_phase
        qenc_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .din    (raw[i]),
            .level  (lvl[i]),
            .toggle (tog[i])
        );
    end

    qmode_e mode_q;
    step_t  stp;

    qenc_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .lvl  (lvl),
        .tog  (tog),
        .stp  (stp)
    );

    logic             enable_q, preload_q, dir_q, ug_q;
    logic [CNT_W-1:0] cnt_q, ceil_act_q, ceil_pend_q, cnt_nxt;

    qenc_wrap #(.CNT_W(CNT_W)) u_wrap (
        .cur  (cnt_q),
        .ceil (ceil_act_q),
        .down (stp.down),
        .nxt  (cnt_nxt)
    );

    logic wr_ctrl, wr_mode, wr_cnt, wr_ceil, wr_upd;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT);
    assign wr_ceil = bus_wr && (bus_addr == ADDR_CEIL);
    assign wr_upd  = bus_wr && (bus_addr == ADDR_UPD);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q    <= 1'b0;
            preload_q   <= 1'b0;
            dir_q       <= 1'b0;
            ug_q        <= 1'b0;
            mode_q      <= MODE_INTCLK;
            cnt_q       <= '0;
            ceil_act_q  <= CEIL_RST;
            ceil_pend_q <= CEIL_RST;
        end else begin
            ug_q <= wr_upd && bus_wdata[0];
            if (wr_ctrl) begin
                enable_q  <= bus_wdata[CTRL_EN_BIT];
                preload_q <= bus_wdata[CTRL_PRE_BIT];
            end
            if (wr_mode) mode_q <= qmode_e'(bus_wdata[1:0]);
            if (wr_ceil) begin
                ceil_pend_q <= bus_wdata;
                if (!preload_q) ceil_act_q <= bus_wdata;
            end
            if (ug_q) ceil_act_q <= ceil_pend_q;
            if (wr_cnt) begin
                cnt_q <= bus_wdata;
            end else if (ug_q) begin
                cnt_q <= dir_q ? ceil_pend_q : '0;
            end else if (enable_q && stp.step) begin
                cnt_q <= cnt_nxt;
                dir_q <= stp.down;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]  = enable_q;
                bus_rdata[CTRL_PRE_BIT] = preload_q;
                bus_rdata[CTRL_DIR_BIT] = dir_q;
            end
            ADDR_MODE: bus_rdata[1:0] = mode_q;
            ADDR_CNT:  bus_rdata = cnt_q;
            ADDR_CEIL: bus_rdata = ceil_act_q;
            ADDR_UPD:  bus_rdata[0] = ug_q;
            default:   bus_rdata = '0;
        endcase
    end

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (enable_q && stp.step && !stp.down && cnt_q >= ceil_act_q && !wr_cnt && !ug_q)
        |=> (cnt_q == '0)); // R6
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (enable_q && stp.step && stp.down && cnt_q == '0 && !wr_cnt && !ug_q)
        |=> (cnt_q == $past(ceil_act_q))); // R6
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!enable_q && !wr_cnt && !ug_q) |=> $stable(cnt_q)); // R8
    AST_CEIL_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        (preload_q && wr_ceil && !ug_q) |=> $stable(ceil_act_q)); // R7
    AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ug_q && !wr_upd) |=> !ug_q); // R9
endmodule

// File: tb/tb_qenc_counter.sv
`timescale 1ns/1ps
module tb_qenc_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    qenc_counter dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int idx = 0, cur_mode = 0;
    bit exp_en = 0, exp_dir = 0;
    int exp_cnt = 0, exp_ceil = 16'hFFFF;
    logic [15:0] rv;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int step_model(input int c, input bit down);
        if (down) return (c == 0) ? exp_ceil : c - 1;
        return (c >= exp_ceil) ? 0 : c + 1;
    endfunction

    // forward phase order AB: 00,10,11,01
    task automatic qstep(input bit fwd, input string req);
        int nidx; bit a_chg; bit counts;
        nidx  = fwd ? (idx + 1) % 4 : (idx + 3) % 4;
        a_chg = fwd ? (idx % 2 == 0) : (nidx % 2 == 0);
        counts = exp_en && ((cur_mode == 3) || (cur_mode == 1 && a_chg) || (cur_mode == 2 && !a_chg));
        @(negedge clk);
        enc_a = (nidx == 1 || nidx == 2);
        enc_b = (nidx == 2 || nidx == 3);
        idx = nidx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (counts) begin
            exp_cnt = step_model(exp_cnt, !fwd);
            exp_dir = !fwd;
        end
        rd(3'd2, rv); chk(req, rv, exp_cnt);
        rd(3'd0, rv); chk({req, " R5 dir"}, rv[3], exp_dir);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        rd(3'd2, rv); chk("R8 reset count", rv, 0);
        rd(3'd0, rv); chk("R5 reset ctrl", rv, 0);
        rd(3'd1, rv); chk("R1 reset mode", rv, 0);
        rd(3'd3, rv); chk("R7 reset ceiling", rv, 16'hFFFF);
        rd(3'd4, rv); chk("R9 reset update", rv, 0);

        // R1: free-running, enable spans 5 waits + 2 edges of the write tasks
        bus_write(3'd0, 16'd1);
        repeat (5) @(negedge clk);
        bus_write(3'd0, 16'd0);
        exp_cnt = 7;
        rd(3'd2, rv); chk("R1 free count", rv, exp_cnt);
        rd(3'd0, rv); chk("R1 R5 dir up", rv[3], 0);
        repeat (5) @(negedge clk);
        rd(3'd2, rv); chk("R8 frozen", rv, exp_cnt);

        bus_write(3'd2, 16'd100); exp_cnt = 100;
        rd(3'd2, rv); chk("R8 count write", rv, 100);
        bus_write(3'd3, 16'd5); exp_ceil = 5;
        rd(3'd3, rv); chk("R7 ceiling direct", rv, 5);

        // R2/R3/R4 sweeps with wrap (R6)
        for (int m = 1; m <= 3; m++) begin
            string tag;
            tag = (m == 1) ? "R2 R6" : (m == 2) ? "R3 R6" : "R4 R6";
            bus_write(3'd1, 16'(m)); cur_mode = m;
            bus_write(3'd2, 16'd3); exp_cnt = 3;
            bus_write(3'd0, 16'd1); exp_en = 1;
            for (int s = 0; s < 10; s++) qstep(1'b1, tag);
            for (int s = 0; s < 10; s++) qstep(1'b0, tag);
            bus_write(3'd0, 16'd0); exp_en = 0;
        end

        // R4: both phases at once is dropped
        bus_write(3'd0, 16'd1); exp_en = 1;
        @(negedge clk); enc_a = 1; enc_b = 1; idx = 2;
        repeat (3) @(posedge clk); @(negedge clk);
        rd(3'd2, rv); chk("R4 double toggle", rv, exp_cnt);
        @(negedge clk); enc_a = 0; enc_b = 0; idx = 0;
        repeat (3) @(posedge clk); @(negedge clk);
        rd(3'd2, rv); chk("R4 double toggle back", rv, exp_cnt);

        // R10: latency of a phase change
        @(negedge clk); enc_a = 1; idx = 1;
        repeat (2) @(posedge clk); @(negedge clk);
        rd(3'd2, rv); chk("R10 not yet", rv, exp_cnt);
        @(posedge clk); @(negedge clk);
        exp_cnt = step_model(exp_cnt, 1'b0); exp_dir = 0;
        rd(3'd2, rv); chk("R10 third edge", rv, exp_cnt);
        qstep(1'b0, "R4 back");

        // R8: phases ignored while disabled
        bus_write(3'd0, 16'd0); exp_en = 0;
        qstep(1'b0, "R8 disabled");
        qstep(1'b1, "R8 disabled");

        // R7/R9: buffered ceiling and update
        bus_write(3'd0, 16'd2);
        bus_write(3'd3, 16'd9);
        rd(3'd3, rv); chk("R7 ceiling pending", rv, 5);
        bus_write(3'd4, 16'd1);
        rd(3'd4, rv); chk("R9 update pulse", rv, 1);
        @(negedge clk);
        exp_ceil = 9;
        exp_cnt = exp_dir ? 9 : 0;
        rd(3'd4, rv); chk("R9 update cleared", rv, 0);
        rd(3'd3, rv); chk("R9 ceiling loaded", rv, 9);
        rd(3'd2, rv); chk("R9 count reload", rv, exp_cnt);

        // free-running wrap at the new ceiling: 8 -> 9 -> 0
        bus_write(3'd1, 16'd0); cur_mode = 0;
        bus_write(3'd2, 16'd8);
        bus_write(3'd0, 16'd3);
        bus_write(3'd0, 16'd2);
        exp_cnt = 0; exp_dir = 0;
        rd(3'd2, rv); chk("R6 R1 wrap", rv, exp_cnt);
        rd(3'd0, rv); chk("R5 dir after up", rv[3], 0);

        // update with direction up loads zero
        bus_write(3'd2, 16'd4);
        bus_write(3'd4, 16'd1);
        @(negedge clk);
        rd(3'd2, rv); chk("R9 reload up", rv, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule